// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Unit

This per-core unit supports atomic read-modify-write sequences built from a load-linked and a store-conditional. A load-linked marks one cache line as reserved by setting a link flag and remembering the line tag. The unit also tracks the coherence state of that line (Invalid, Shared or Modified). A remote invalidation of the line breaks the reservation. A local eviction moves the line to Invalid but keeps the reservation.

The pipeline presents a store-conditional only when it is the oldest instruction, so the unit never runs one speculatively. If the reservation is already broken, or belongs to another line, the store fails at once and touches neither the cache nor the bus. Otherwise the unit gets write ownership if it does not already hold it. It requests read-exclusive from Invalid and an upgrade from Shared. Once the grant arrives it tests the flag again, then either writes the cache or fails. The line is Modified after the grant in both cases. A one-cycle `sc_done` pulse releases dependent instructions and carries the 1/0 outcome.

Top module: `llsc_monitor`

## Requirements
- R1: After reset the link flag is clear and `line_state` is Invalid (code 0). `bus_req`, `cache_we` and `sc_done` are low.
- R2: A load-linked sets the link flag and takes the tag `ll_addr[AW-1:6]` (64-byte lines). The line is Shared (code 1) afterwards, unless it was the same line already valid, in which case its state is kept.
- R3: `snoop_inv` to the tracked line clears the link flag and makes the line Invalid. A snoop to any other line has no effect.
- R4: A store-conditional with the flag clear, or to a different line, completes the cycle after `sc_valid` with `sc_result`=0. It raises neither `bus_req` nor `cache_we`.
- R5: With the flag set, `bus_req` rises the cycle after `sc_valid`. `bus_type` is 0 (read-exclusive) from Invalid and 1 (upgrade) from Shared. It stays high until a cycle with `bus_grant`.
- R6: With the flag set and the line Modified, no bus request is made. The cycle after `sc_valid` shows `cache_we`, `sc_done` and `sc_result`=1, with the store address and data.
- R7: The cycle after the grant, the flag is tested again. If it is still set and no matching snoop is present, the store writes and returns 1. Otherwise it returns 0 without a write.
- R8: The line is Modified the cycle after a grant, even when the flag was cleared while waiting. A snoop in the recheck cycle leaves it Invalid.
- R9: `sc_done` is a single-cycle pulse per store-conditional. A successful store clears the flag, so a repeated store-conditional fails.
- R10: A matching snoop while the request is pending switches `bus_type` to read-exclusive from the next cycle.
- R11: `evict` to the tracked line makes it Invalid and keeps the flag. The next store-conditional then requests read-exclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ll_valid | input | 1 | Load-linked issued |
| ll_addr | input | AW | Load-linked byte address |
| sc_valid | input | 1 | Non-speculative store-conditional start |
| sc_addr | input | AW | Store-conditional byte address |
| sc_data | input | DW | Store-conditional data |
| snoop_inv | input | 1 | Remote write invalidation |
| snoop_addr | input | AW | Invalidated address |
| evict | input | 1 | Local replacement of a line |
| evict_addr | input | AW | Evicted address |
| bus_grant | input | 1 | Bus grants the pending request |
| bus_req | output | 1 | Ownership request pending |
| bus_type | output | 1 | 0 read-exclusive, 1 upgrade |
| bus_addr | output | AW | Line address of the request |
| cache_we | output | 1 | Cache write strobe |
| cache_addr | output | AW | Cache write address |
| cache_wdata | output | DW | Cache write data |
| sc_done | output | 1 | Store-conditional complete, dependents may go |
| sc_result | output | 1 | 1 success, 0 failure |
| line_state | output | 2 | Tracked line state (0 I, 1 S, 2 M) |

## Verification
The bench goes after the window between the request and the write. Snoops land while the grant is outstanding and again in the recheck cycle. A design that trusted the first check would report success there, and one that skipped the ownership change on failure would leave the line non-Modified. It also tests store-conditionals with a broken or mismatched reservation, where a careless design would still issue a bus request. Eviction followed by a store checks that the request kind follows the line state and not the flag. Repeated stores check that success consumes the reservation.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
    typedef enum logic [1:0] {
        LINE_I = 2'd0,
        LINE_S = 2'd1,
        LINE_M = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_BUS   = 2'd1,
        SEQ_CHECK = 2'd2
    } seq_st_e;

    localparam logic REQ_RDX = 1'b0;
    localparam logic REQ_UPG = 1'b1;
endpackage

// File: rtl/llsc_link_track.sv
module llsc_link_track
    import llsc_pkg::*;
#(
    parameter int TAGW = 26
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ll_fire,
    input  logic [TAGW-1:0] ll_tag,
    input  logic            snoop_inv,
    input  logic [TAGW-1:0] snoop_tag,
    input  logic            evict,
    input  logic [TAGW-1:0] evict_tag,
    input  logic            own_grant,
    input  logic            link_drop,
    output logic            link_o,
    output logic [TAGW-1:0] tag_o,
    output line_st_e        state_o,
    output logic            snoop_hit_o
);
    typedef struct packed {
        logic            link;
        logic [TAGW-1:0] tag;
        line_st_e        st;
    } trk_t;

    trk_t trk_d, trk_q;
    logic snoop_hit;
    logic evict_hit;

    always_comb begin
        snoop_hit = snoop_inv && (snoop_tag == trk_q.tag)
                    && (trk_q.link || trk_q.st != LINE_I);
        evict_hit = evict && (evict_tag == trk_q.tag);
        trk_d = trk_q;
        if (snoop_hit) begin
            trk_d.link = 1'b0;
            trk_d.st   = LINE_I;
        end
        if (evict_hit) begin
            trk_d.st = LINE_I;
        end
        if (own_grant) begin
            trk_d.st = LINE_M;
        end
        if (link_drop) begin
            trk_d.link = 1'b0;
        end
        if (ll_fire) begin
            if (ll_tag != trk_q.tag || trk_d.st == LINE_I) begin
                trk_d.st = LINE_S;
            end
            trk_d.tag  = ll_tag;
            trk_d.link = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '{link: 1'b0, tag: '0, st: LINE_I};
        end else begin
            trk_q <= trk_d;
        end
    end

    assign link_o      = trk_q.link;
    assign tag_o       = trk_q.tag;
    assign state_o     = trk_q.st;
    assign snoop_hit_o = snoop_hit;
endmodule

// File: rtl/llsc_req_sel.sv
module llsc_req_sel
    import llsc_pkg::*;
#(
    parameter int AW   = 32,
    parameter int OFFW = 6
) (
    input  line_st_e             state,
    input  logic [AW-OFFW-1:0]   tag,
    output logic                 bus_type,
    output logic [AW-1:0]        bus_addr
);
    always_comb begin
        unique case (state)
            LINE_S:  bus_type = REQ_UPG;
            default: bus_type = REQ_RDX;
        endcase
        bus_addr = {tag, {OFFW{1'b0}}};
    end
endmodule

// File: rtl/llsc_sc_seq.sv
module llsc_sc_seq
    import llsc_pkg::*;
#(
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int OFFW = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sc_valid,
    input  logic [AW-1:0]       sc_addr,
    input  logic [DW-1:0]       sc_data,
    input  logic                link,
    input  logic [AW-OFFW-1:0]  tag,
    input  line_st_e            state,
    input  logic                snoop_hit,
    input  logic                bus_grant,
    output logic                ll_allow,
    output logic                own_grant,
    output logic                link_drop,
    output logic                bus_req,
    output logic                cache_we,
    output logic [AW-1:0]       cache_addr,
    output logic [DW-1:0]       cache_wdata,
    output logic                sc_done,
    output logic                sc_result
);
    typedef struct packed {
        seq_st_e       st;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          done;
        logic          res;
        logic          we;
    } seq_t;

    seq_t seq_d, seq_q;
    logic linked;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.res  = 1'b0;
        seq_d.we   = 1'b0;
        own_grant  = 1'b0;
        link_drop  = 1'b0;
        linked     = link && !snoop_hit && (sc_addr[AW-1:OFFW] == tag);
        unique case (seq_q.st)
            SEQ_IDLE: begin
                if (sc_valid) begin
                    seq_d.addr = sc_addr;
                    seq_d.data = sc_data;
                    if (!linked) begin
                        seq_d.done = 1'b1;
                    end else if (state == LINE_M) begin
                        seq_d.we   = 1'b1;
                        seq_d.done = 1'b1;
                        seq_d.res  = 1'b1;
                        link_drop  = 1'b1;
                    end else begin
                        seq_d.st = SEQ_BUS;
                    end
                end
            end
            SEQ_BUS: begin
                if (bus_grant) begin
                    own_grant = 1'b1;
                    seq_d.st  = SEQ_CHECK;
                end
            end
            SEQ_CHECK: begin
                seq_d.st   = SEQ_IDLE;
                seq_d.done = 1'b1;
                if (link && !snoop_hit) begin
                    seq_d.we  = 1'b1;
                    seq_d.res = 1'b1;
                    link_drop = 1'b1;
                end
            end
            default: seq_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: SEQ_IDLE, addr: '0, data: '0, done: 1'b0, res: 1'b0, we: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ll_allow    = (seq_q.st == SEQ_IDLE) && !sc_valid;
    assign bus_req     = (seq_q.st == SEQ_BUS);
    assign cache_we    = seq_q.we;
    assign cache_addr  = seq_q.addr;
    assign cache_wdata = seq_q.data;
    assign sc_done     = seq_q.done;
    assign sc_result   = seq_q.res;
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int LINE_BYTES = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ll_valid,
    input  logic [AW-1:0] ll_addr,
    input  logic          sc_valid,
    input  logic [AW-1:0] sc_addr,
    input  logic [DW-1:0] sc_data,
    input  logic          snoop_inv,
    input  logic [AW-1:0] snoop_addr,
    input  logic          evict,
    input  logic [AW-1:0] evict_addr,
    input  logic          bus_grant,
    output logic          bus_req,
    output logic          bus_type,
    output logic [AW-1:0] bus_addr,
    output logic          cache_we,
    output logic [AW-1:0] cache_addr,
    output logic [DW-1:0] cache_wdata,
    output logic          sc_done,
    output logic          sc_result,
    output logic [1:0]    line_state
);
    localparam int OFFW = $clog2(LINE_BYTES);
    localparam int TAGW = AW - OFFW;

    logic            link;
    logic [TAGW-1:0] tag;
    line_st_e        state;
    logic            snoop_hit;
    logic            ll_allow;
    logic            own_grant;
    logic            link_drop;

    llsc_link_track #(.TAGW(TAGW)) track_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ll_fire    (ll_valid && ll_allow),
        .ll_tag     (ll_addr[AW-1:OFFW]),
        .snoop_inv  (snoop_inv),
        .snoop_tag  (snoop_addr[AW-1:OFFW]),
        .evict      (evict),
        .evict_tag  (evict_addr[AW-1:OFFW]),
        .own_grant  (own_grant),
        .link_drop  (link_drop),
        .link_o     (link),
        .tag_o      (tag),
        .state_o    (state),
        .snoop_hit_o(snoop_hit)
    );

    llsc_req_sel #(.AW(AW), .OFFW(OFFW)) sel_i (
        .state   (state),
        .tag     (tag),
        .bus_type(bus_type),
        .bus_addr(bus_addr)
    );

    llsc_sc_seq #(.AW(AW), .DW(DW), .OFFW(OFFW)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sc_valid   (sc_valid),
        .sc_addr    (sc_addr),
        .sc_data    (sc_data),
        .link       (link),
        .tag        (tag),
        .state      (state),
        .snoop_hit  (snoop_hit),
        .bus_grant  (bus_grant),
        .ll_allow   (ll_allow),
        .own_grant  (own_grant),
        .link_drop  (link_drop),
        .bus_req    (bus_req),
        .cache_we   (cache_we),
        .cache_addr (cache_addr),
        .cache_wdata(cache_wdata),
        .sc_done    (sc_done),
        .sc_result  (sc_result)
    );

    assign line_state = state;
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_req,
    input logic       bus_grant,
    input logic       cache_we,
    input logic       sc_done,
    input logic       sc_result,
    input logic       sc_valid,
    input logic [1:0] line_state
);
    // R5
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_grant |=> bus_req);

    // R8
    grant_to_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_grant |=> line_state == 2'd2);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_done |=> !sc_done);

    // R7
    we_only_success_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cache_we |-> sc_done && sc_result);

    // R4
    result_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_result |-> sc_done);

    // R1
    idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !bus_req && !sc_done && line_state == 2'd0);
endmodule

bind llsc_monitor llsc_monitor_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_grant (bus_grant),
    .cache_we  (cache_we),
    .sc_done   (sc_done),
    .sc_result (sc_result),
    .sc_valid  (sc_valid),
    .line_state(line_state)
);

// File: tb/llsc_monitor_tb_top.sv
module llsc_monitor_tb_top;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ll_valid = 1'b0;
    logic [AW-1:0] ll_addr = '0;
    logic          sc_valid = 1'b0;
    logic [AW-1:0] sc_addr = '0;
    logic [DW-1:0] sc_data = '0;
    logic          snoop_inv = 1'b0;
    logic [AW-1:0] snoop_addr = '0;
    logic          evict = 1'b0;
    logic [AW-1:0] evict_addr = '0;
    logic          bus_grant = 1'b0;
    logic          bus_req, bus_type, cache_we, sc_done, sc_result;
    logic [AW-1:0] bus_addr, cache_addr;
    logic [DW-1:0] cache_wdata;
    logic [1:0]    line_state;

    int n_checks = 0;
    int n_err = 0;
    bit finished = 1'b0;

    bit        m_link = 1'b0;
    bit [25:0] m_tag = '0;
    int        m_st = 0;

    always #10 clk = ~clk;

    llsc_monitor dut_i (.*);

    function automatic bit [25:0] tag_of(input logic [AW-1:0] a);
        return a[AW-1:6];
    endfunction

    function automatic logic [AW-1:0] pick_addr(input int line);
        return 32'h0000_4000 + 32'(line * 64) + 32'(($urandom % 16) * 4);
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_ll(input logic [AW-1:0] a);
        ll_valid = 1'b1;
        ll_addr  = a;
        tick();
        ll_valid = 1'b0;
        if (tag_of(a) != m_tag || m_st == 0) m_st = 1;
        m_tag  = tag_of(a);
        m_link = 1'b1;
        chk("R2 line_state after load-linked", line_state, m_st);
    endtask

    task automatic do_snoop(input logic [AW-1:0] a);
        snoop_inv  = 1'b1;
        snoop_addr = a;
        tick();
        snoop_inv = 1'b0;
        if (tag_of(a) == m_tag) begin
            m_link = 1'b0;
            m_st   = 0;
        end
        chk("R3 line_state after snoop", line_state, m_st);
    endtask

    task automatic do_evict(input logic [AW-1:0] a);
        evict      = 1'b1;
        evict_addr = a;
        tick();
        evict = 1'b0;
        if (tag_of(a) == m_tag) m_st = 0;
        chk("R11 line_state after evict", line_state, m_st);
    endtask

    task automatic do_sc(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input int wait_n, input bit snoop_wait, input bit snoop_chk);
        bit linked;
        bit ok;
        linked   = m_link && (tag_of(a) == m_tag);
        sc_valid = 1'b1;
        sc_addr  = a;
        sc_data  = d;
        tick();
        sc_valid = 1'b0;
        if (!linked) begin
            chk("R4 done on failed start", sc_done, 1);
            chk("R4 result on failed start", sc_result, 0);
            chk("R4 no bus request", bus_req, 0);
            chk("R4 no cache write", cache_we, 0);
        end else if (m_st == 2) begin
            chk("R6 done from Modified", sc_done, 1);
            chk("R6 result from Modified", sc_result, 1);
            chk("R6 write strobe", cache_we, 1);
            chk("R6 write address", cache_addr, a);
            chk("R6 write data", cache_wdata, d);
            chk("R6 no bus request", bus_req, 0);
            m_link = 1'b0;
        end else begin
            chk("R5 bus request raised", bus_req, 1);
            chk("R5 request kind", bus_type, (m_st == 1) ? 1 : 0);
            chk("R5 request line", bus_addr, {tag_of(a), 6'd0});
            chk("R5 not done while waiting", sc_done, 0);
            for (int i = 0; i < wait_n; i++) begin
                if (snoop_wait && i == 0) begin
                    snoop_inv  = 1'b1;
                    snoop_addr = a;
                end
                tick();
                snoop_inv = 1'b0;
                if (snoop_wait && i == 0) begin
                    m_link = 1'b0;
                    m_st   = 0;
                    chk("R10 kind after snoop in wait", bus_type, 0);
                end
                chk("R5 request held", bus_req, 1);
            end
            bus_grant = 1'b1;
            tick();
            bus_grant = 1'b0;
            m_st = 2;
            chk("R8 Modified after grant", line_state, 2);
            chk("R5 request dropped after grant", bus_req, 0);
            chk("R7 not done before recheck", sc_done, 0);
            if (snoop_chk) begin
                snoop_inv  = 1'b1;
                snoop_addr = a;
            end
            tick();
            snoop_inv = 1'b0;
            ok = m_link && !snoop_chk;
            chk("R7 done after recheck", sc_done, 1);
            chk("R7 recheck result", sc_result, ok);
            chk("R7 recheck write", cache_we, ok);
            if (ok) begin
                chk("R7 write address", cache_addr, a);
                chk("R7 write data", cache_wdata, d);
            end
            m_link = 1'b0;
            if (snoop_chk) m_st = 0;
            chk("R8 final line state", line_state, m_st);
        end
        tick();
        chk("R9 done is one pulse", sc_done, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] la, lb, lc;
        void'($urandom(32'd7715));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 line_state", line_state, 0);
        chk("R1 bus_req", bus_req, 0);
        chk("R1 sc_done", sc_done, 0);
        chk("R1 cache_we", cache_we, 0);

        la = pick_addr(0);
        lb = pick_addr(1);
        lc = pick_addr(2);
        do_sc(la, 32'h1111, 0, 0, 0);          // R1 R4: no reservation
        do_ll(la);                              // R2 Shared
        do_sc(la, 32'hA5A5, 2, 0, 0);          // R5 upgrade, R7 success
        do_sc(la, 32'hBEEF, 0, 0, 0);          // R9 consumed
        do_ll(la);                              // R2 keeps Modified
        chk("R2 Modified kept", line_state, 2);
        do_sc(la + 4, 32'hC0DE, 0, 0, 0);      // R6 no bus
        do_ll(lb);
        do_snoop(la);                           // R3 other line
        do_snoop(lb);                           // R3 own line
        do_sc(lb, 32'h2222, 0, 0, 0);          // R4
        do_ll(lc);
        do_sc(lb, 32'h3333, 0, 0, 0);          // R4 wrong line
        do_ll(lc);
        do_sc(lc, 32'h4444, 2, 1, 0);          // R10 R8 snoop in wait
        do_ll(lb);
        do_sc(lb, 32'h5555, 1, 0, 1);          // R7 R8 snoop in recheck
        do_ll(la);
        do_evict(la);                           // R11
        do_sc(la, 32'h6666, 1, 0, 0);          // R11 read-exclusive, success

        for (int it = 0; it < 400; it++) begin
            int op;
            int w;
            logic [AW-1:0] a;
            op = int'($urandom % 5);
            a  = pick_addr(int'($urandom % 3));
            w  = 1 + int'($urandom % 3);
            case (op)
                0, 1: do_ll(a);
                2: do_sc(($urandom % 3 == 0) ? a : {m_tag, 6'd8}, $urandom, w,
                         ($urandom % 4) == 0, ($urandom % 6) == 0);
                3: do_snoop(a);
                default: do_evict(a);
            endcase
        end

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule